// File: doc/BRIEF.md
# DDR SDRAM Burst Write Capture

This block is the write-side datapath of a double-data-rate SDRAM-style memory. It watches the four active-low command pins on each rising clock edge. When they carry a write, it records the starting column and opens a burst of four beats. The data strobe is presented in the clock domain as two bits per cycle. One bit says whether the strobe is driven at all. The other says whether the strobe made a rise/fall pair of edges in that cycle. When it did, the two data inputs carry the beat taken on the rising edge and the beat taken on the following falling edge.

Capture is allowed only after the strobe has been seen driven and idle, which models the low preamble that follows high impedance. The burst then fills two beats per strobe cycle into a 16 x 8 array. Columns advance with wrap inside the aligned group of four. Beats that arrive once no burst is open are dropped. A new write issued on the edge that takes the last pair of the current burst chains on without a gap. A write issued any earlier is refused and flagged.

The array has a registered read port so the contents can be inspected. Per-beat valid and end-of-burst pulses are exported next to it.

Top module: `ddr_wr_capture`

## Requirements
- R1: A write is decoded only when, at a rising clock edge, cs_n=0, ras_n=1, cas_n=0 and we_n=0 (pin order {cs_n,ras_n,cas_n,we_n}=4'b0100). Any other pin pattern opens no burst, for example 4'b0011 or 4'b1100.
- R2: The four beats of a burst started at column S go to columns {S[3:2], S[1:0]+i} for i = 0..3, with the low two bits wrapping modulo 4.
- R3: A cycle with dqs_toggle=1 while a burst is open captures two beats. dq_rise is the earlier beat and dq_fall the later one. The first such cycle after the command edge carries beats 0 and 1, and the next carries beats 2 and 3. The burst waits while the strobe does not toggle.
- R4: Strobe toggles while no burst is open write nothing and leave the array unchanged.
- R5: A toggle is captured only if, at an earlier edge, dqs_drive=1 with dqs_toggle=0, and dqs_drive has stayed 1 since then. An edge with dqs_drive=0 clears this armed state.
- R6: A write decoded on the same edge as the last pair of the open burst is accepted. Its first pair is taken on the very next toggle cycle, and proto_err stays 0.
- R7: A write decoded while the open burst has two pairs left, or has one pair left and no toggle on that edge, is discarded. It raises proto_err for one cycle and does not disturb the open burst.
- R8: beat_vld is 2'b11 for one cycle after each captured pair. burst_done is 1 for one cycle after the pair carrying beats 2 and 3.
- R9: Synchronous active-high reset clears beat_vld, burst_done, proto_err, any open burst and the armed strobe state.
- R10: rd_data shows the array byte at column rd_col sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| col_addr | input | 4 | Starting column sampled with a write |
| dqs_drive | input | 1 | Data strobe is being driven (not high impedance) |
| dqs_toggle | input | 1 | Strobe made a rise then fall edge in this cycle |
| dq_rise | input | 8 | Data beat taken on the strobe rising edge |
| dq_fall | input | 8 | Data beat taken on the strobe falling edge |
| rd_col | input | 4 | Array read column |
| rd_data | output | 8 | Array byte at rd_col, one cycle later |
| beat_vld | output | 2 | Rise/fall beats written on the previous edge |
| burst_done | output | 1 | Last pair of a burst written on the previous edge |
| proto_err | output | 1 | A write was refused on the previous edge |

## Verification
Single bursts start at aligned columns, which fills the whole array and shows that the rise and fall beats are not swapped. They also start at unaligned columns, where a wrong wrap lands the beats in the neighbouring group. Chained writes on the last-pair edge are set against early writes at two distances, separating seamless acceptance from refusal. Strobe patterns without a preamble, toggles after the burst has closed, and non-write pin patterns with a preamble show that only an armed strobe inside an open burst changes the array. The array is read back in full after each case.

// File: rtl/ddr_wr_pkg.sv
package ddr_wr_pkg;

  // Command pins as seen at a rising clock edge, all active low.
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } ctl_pins_t;

  // Write pattern: chip selected, column and write strobes low, row strobe high.
  localparam ctl_pins_t CTL_WRITE = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};

  localparam int unsigned DEF_COL_W  = 4;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_BURST  = 4;

endpackage

// File: rtl/ddr_wr_cmd_dec.sv
module ddr_wr_cmd_dec
  import ddr_wr_pkg::*;
(
  input  ctl_pins_t pins,
  output logic      is_write
);

  always_comb begin
    is_write = (pins == CTL_WRITE);
  end

endmodule

// File: rtl/ddr_wr_strobe_arm.sv
module ddr_wr_strobe_arm (
  input  logic clk,
  input  logic rst,
  input  logic dqs_drive,
  input  logic dqs_toggle,
  output logic pair_ok
);

  logic armed_q;

  // Armed once the strobe has been driven without edges (preamble);
  // stays armed while driven, drops when released to high impedance.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
    end else if (!dqs_drive) begin
      armed_q <= 1'b0;
    end else if (!dqs_toggle) begin
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    pair_ok = armed_q && dqs_drive && dqs_toggle;
  end

endmodule

// File: rtl/ddr_wr_burst_seq.sv
module ddr_wr_burst_seq #(
  parameter int unsigned COL_W     = 4,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cmd,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             pair_in,
  output logic             cap,
  output logic             last,
  output logic             err,
  output logic [COL_W-1:0] col_rise,
  output logic [COL_W-1:0] col_fall
);

  localparam int unsigned PAIRS = BURST_LEN / 2;
  localparam int unsigned GRP_W = $clog2(BURST_LEN);
  localparam int unsigned PW    = $clog2(PAIRS + 1);

  logic [PW-1:0]    pend_q;
  logic [COL_W-1:0] base_q;
  logic [GRP_W-1:0] ofs;
  logic             accept;

  always_comb begin
    cap    = pair_in && (pend_q != '0);
    last   = cap && (pend_q == PW'(1));
    accept = wr_cmd && ((pend_q == '0) || last);
    err    = wr_cmd && !accept;
    ofs    = GRP_W'((PAIRS - 32'(pend_q)) * 2);
    col_rise = {base_q[COL_W-1:GRP_W], base_q[GRP_W-1:0] + ofs};
    col_fall = {base_q[COL_W-1:GRP_W], base_q[GRP_W-1:0] + ofs + GRP_W'(1)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      base_q <= '0;
    end else if (accept) begin
      pend_q <= PW'(PAIRS);
      base_q <= cmd_col;
    end else if (cap) begin
      pend_q <= pend_q - PW'(1);
    end
  end

endmodule

// File: rtl/ddr_wr_bank.sv
module ddr_wr_bank #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // One write and one registered read port: maps onto a simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ddr_wr_capture.sv
module ddr_wr_capture
  import ddr_wr_pkg::*;
#(
  parameter int unsigned COL_W     = DEF_COL_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned BURST_LEN = DEF_BURST
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [COL_W-1:0]  col_addr,
  input  logic              dqs_drive,
  input  logic              dqs_toggle,
  input  logic [DATA_W-1:0] dq_rise,
  input  logic [DATA_W-1:0] dq_fall,
  input  logic [COL_W-1:0]  rd_col,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        beat_vld,
  output logic              burst_done,
  output logic              proto_err
);

  localparam int unsigned BANK_AW = COL_W - 1;

  ctl_pins_t        pins;
  logic             is_write;
  logic             pair_ok;
  logic             cap;
  logic             last;
  logic             err;
  logic [COL_W-1:0] col_rise;
  logic [COL_W-1:0] col_fall;
  logic             unused_fall_lsb;
  logic             rd_sel_q;
  logic [DATA_W-1:0] bank_rd [2];

  assign pins = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};
  assign unused_fall_lsb = col_fall[0];

  ddr_wr_cmd_dec u_dec (
    .pins     (pins),
    .is_write (is_write)
  );

  ddr_wr_strobe_arm u_arm (
    .clk        (clk),
    .rst        (rst),
    .dqs_drive  (dqs_drive),
    .dqs_toggle (dqs_toggle),
    .pair_ok    (pair_ok)
  );

  ddr_wr_burst_seq #(
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr_cmd   (is_write),
    .cmd_col  (col_addr),
    .pair_in  (pair_ok),
    .cap      (cap),
    .last     (last),
    .err      (err),
    .col_rise (col_rise),
    .col_fall (col_fall)
  );

  // Rise and fall beats of a pair always differ in column parity, so the
  // array is split into an even and an odd bank with one write each per cycle.
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic               rise_here;
    logic [BANK_AW-1:0] waddr;
    logic [DATA_W-1:0]  wdata;

    always_comb begin
      rise_here = (col_rise[0] == (b == 1));
      waddr     = rise_here ? col_rise[COL_W-1:1] : col_fall[COL_W-1:1];
      wdata     = rise_here ? dq_rise : dq_fall;
    end

    ddr_wr_bank #(
      .AW (BANK_AW),
      .DW (DATA_W)
    ) u_bank (
      .clk   (clk),
      .we    (cap),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (rd_col[COL_W-1:1]),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_vld   <= 2'b00;
      burst_done <= 1'b0;
      proto_err  <= 1'b0;
      rd_sel_q   <= 1'b0;
    end else begin
      beat_vld   <= {2{cap}};
      burst_done <= last;
      proto_err  <= err;
      rd_sel_q   <= rd_col[0];
    end
  end

  assign rd_data = bank_rd[rd_sel_q];

endmodule

// File: rtl/ddr_wr_capture_chk.sv
module ddr_wr_capture_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       dqs_drive,
  input logic       dqs_toggle,
  input logic [1:0] beat_vld,
  input logic       burst_done,
  input logic       proto_err
);

  // R9: outputs are quiet on the first edge after reset
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (beat_vld == 2'b00 && !burst_done && !proto_err));

  // R5: nothing is taken while the strobe is released
  a_r5_no_cap_undriven: assert property (@(posedge clk) disable iff (rst)
    !$past(dqs_drive) |-> beat_vld == 2'b00);

  // R5: a strobe that starts toggling straight out of high impedance is not armed
  a_r5_needs_preamble: assert property (@(posedge clk) disable iff (rst)
    ($past(dqs_drive) && !$past(dqs_drive, 2)) |-> beat_vld == 2'b00);

  // R3: a pair is written only on a toggle cycle
  a_r3_vld_needs_toggle: assert property (@(posedge clk) disable iff (rst)
    !$past(dqs_toggle) |-> beat_vld == 2'b00);

  // R8: burst end coincides with a written pair
  a_r8_done_with_pair: assert property (@(posedge clk) disable iff (rst)
    burst_done |-> beat_vld == 2'b11);

  // R8: a burst spans two pairs, so end pulses are never adjacent
  a_r8_done_spacing: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);

  // R7: an error is only raised for a decoded write
  a_r7_err_needs_write: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> $past(!cs_n && ras_n && !cas_n && !we_n));

endmodule

bind ddr_wr_capture ddr_wr_capture_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .ras_n      (ras_n),
  .cas_n      (cas_n),
  .we_n       (we_n),
  .dqs_drive  (dqs_drive),
  .dqs_toggle (dqs_toggle),
  .beat_vld   (beat_vld),
  .burst_done (burst_done),
  .proto_err  (proto_err)
);

// File: tb/ddr_wr_capture_bench.sv
module ddr_wr_capture_bench;

  localparam logic [3:0] CMD_WR    = 4'b0100;
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_ACT   = 4'b0011;
  localparam logic [3:0] CMD_DESEL = 4'b1100;

  // {start column, beat3, beat2, beat1, beat0}
  localparam int NVEC = 8;
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd0,  32'h13_12_11_10},
    {4'd4,  32'h27_26_25_24},
    {4'd8,  32'h3B_3A_39_38},
    {4'd12, 32'h4F_4E_4D_4C},
    {4'd6,  32'h55_54_57_56},
    {4'd9,  32'h68_6B_6A_69},
    {4'd15, 32'h7E_7D_7C_7F},
    {4'd3,  32'h82_81_80_83}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [3:0] col_addr = '0;
  logic       dqs_drive = 1'b0, dqs_toggle = 1'b0;
  logic [7:0] dq_rise = '0, dq_fall = '0;
  logic [3:0] rd_col = '0;
  logic [7:0] rd_data;
  logic [1:0] beat_vld;
  logic       burst_done, proto_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_mem [16];

  always #4 clk = ~clk;

  ddr_wr_capture u_ddr_wr_capture (
    .clk (clk), .rst (rst),
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .col_addr (col_addr), .dqs_drive (dqs_drive), .dqs_toggle (dqs_toggle),
    .dq_rise (dq_rise), .dq_fall (dq_fall), .rd_col (rd_col),
    .rd_data (rd_data), .beat_vld (beat_vld),
    .burst_done (burst_done), .proto_err (proto_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] ctl, input logic [3:0] col, input logic drv,
                     input logic tog, input logic [7:0] dr, input logic [7:0] df);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = ctl;
    col_addr = col; dqs_drive = drv; dqs_toggle = tog; dq_rise = dr; dq_fall = df;
    @(posedge clk); #1;
  endtask

  task automatic outs(input string tag, input logic [1:0] v, input logic d, input logic e);
    chk({tag, " beat_vld"}, 32'(beat_vld), 32'(v));
    chk({tag, " burst_done"}, 32'(burst_done), 32'(d));
    chk({tag, " proto_err"}, 32'(proto_err), 32'(e));
  endtask

  function automatic logic [3:0] bcol(input logic [3:0] s, input int i);
    return {s[3:2], 2'(s[1:0] + 2'(i))};
  endfunction

  task automatic shadow(input logic [3:0] s, input logic [31:0] d);
    for (int i = 0; i < 4; i++) exp_mem[bcol(s, i)] = d[8*i +: 8];
  endtask

  task automatic verify(input string tag);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      rd_col = 4'(c);
      {cs_n, ras_n, cas_n, we_n} = CMD_NOP;
      dqs_toggle = 1'b0;
      @(posedge clk); #1;
      chk($sformatf("%s R10 col %0d", tag, c), 32'(rd_data), 32'(exp_mem[c]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    outs("R9 in reset", 2'b00, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;

    // Table: single bursts (R2, R3, R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0]  s;
      logic [31:0] d;
      s = VEC[v][35:32];
      d = VEC[v][31:0];
      cyc(CMD_WR, s, 1'b1, 1'b0, 8'h00, 8'h00);
      outs("R3 cmd edge", 2'b00, 1'b0, 1'b0);
      cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, d[7:0], d[15:8]);
      outs("R8 pair0", 2'b11, 1'b0, 1'b0);
      cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, d[23:16], d[31:24]);
      outs("R8 pair1", 2'b11, 1'b1, 1'b0);
      cyc(CMD_NOP, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00);
      shadow(s, d);
    end
    verify("R2 table");

    // R1: non-write patterns with an armed strobe open nothing
    cyc(CMD_ACT, 4'd0, 1'b1, 1'b0, 8'h00, 8'h00);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hAA, 8'hBB);
    outs("R1 act pattern", 2'b00, 1'b0, 1'b0);
    cyc(CMD_DESEL, 4'd4, 1'b1, 1'b1, 8'hCC, 8'hDD);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hCC, 8'hDD);
    outs("R1 deselected", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    verify("R1");

    // R4: beats after the burst are dropped
    cyc(CMD_WR, 4'd10, 1'b1, 1'b0, 8'h00, 8'h00);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'h90, 8'h91);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'h92, 8'h93);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hEE, 8'hEF);
    outs("R4 extra beats", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hE0, 8'hE1);
    outs("R4 extra beats 2", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    shadow(4'd10, 32'h93_92_91_90);
    verify("R4");

    // R6: chained write on the last-pair edge
    cyc(CMD_WR, 4'd1, 1'b1, 1'b0, 8'h00, 8'h00);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hA0, 8'hA1);
    cyc(CMD_WR, 4'd13, 1'b1, 1'b1, 8'hA2, 8'hA3);
    outs("R6 chain edge", 2'b11, 1'b1, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hB0, 8'hB1);
    outs("R6 second pair0", 2'b11, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hB2, 8'hB3);
    outs("R6 second pair1", 2'b11, 1'b1, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    shadow(4'd1, 32'hA3_A2_A1_A0);
    shadow(4'd13, 32'hB3_B2_B1_B0);
    verify("R6");

    // R7: write one cycle after the command is refused
    cyc(CMD_WR, 4'd4, 1'b1, 1'b0, 8'h00, 8'h00);
    cyc(CMD_WR, 4'd8, 1'b1, 1'b1, 8'hC0, 8'hC1);
    outs("R7 early write", 2'b11, 1'b0, 1'b1);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hC2, 8'hC3);
    outs("R7 old burst ends", 2'b11, 1'b1, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hF0, 8'hF1);
    outs("R7 refused burst empty", 2'b00, 1'b0, 1'b0);
    shadow(4'd4, 32'hC3_C2_C1_C0);
    // R7: write with one pair left and no toggle is refused
    cyc(CMD_WR, 4'd14, 1'b1, 1'b0, 8'h00, 8'h00);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hD0, 8'hD1);
    cyc(CMD_WR, 4'd0, 1'b1, 1'b0, 8'h00, 8'h00);
    outs("R7 stalled write", 2'b00, 1'b0, 1'b1);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hD2, 8'hD3);
    outs("R7 stalled burst ends", 2'b11, 1'b1, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'hF2, 8'hF3);
    outs("R7 second refused empty", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    shadow(4'd14, 32'hD3_D2_D1_D0);
    verify("R7");

    // R5: no preamble means no capture; the burst waits for an armed strobe
    cyc(CMD_WR, 4'd7, 1'b0, 1'b0, 8'h00, 8'h00);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'h11, 8'h22);
    outs("R5 no preamble", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'h33, 8'h44);
    outs("R5 still unarmed", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b0, 8'h00, 8'h00);
    outs("R5 preamble cycle", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'h5A, 8'h5B);
    outs("R5 armed pair0", 2'b11, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'h5C, 8'h5D);
    outs("R5 armed pair1", 2'b11, 1'b1, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    shadow(4'd7, 32'h5D_5C_5B_5A);
    verify("R5");

    // R9: reset aborts an open burst and disarms the strobe
    cyc(CMD_WR, 4'd2, 1'b1, 1'b0, 8'h00, 8'h00);
    @(negedge clk); rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = CMD_NOP; dqs_drive = 1'b1; dqs_toggle = 1'b0;
    @(posedge clk); #1;
    outs("R9 reset mid burst", 2'b00, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b0, 8'h00, 8'h00);
    cyc(CMD_NOP, 4'd0, 1'b1, 1'b1, 8'h66, 8'h77);
    outs("R9 burst cleared", 2'b00, 1'b0, 1'b0);
    cyc(CMD_NOP, 4'd0, 1'b0, 1'b0, 8'h00, 8'h00);
    verify("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule